// File: doc/BRIEF.md
# Paired-Input Conversion Request Sequencer

This block takes conversion requests for six pairs of analog inputs and runs them through a single shared converter. Each pair has its own trigger line. A trigger is held in a one-bit latch until the pair is served. When several latches are set, the lowest-numbered pair always wins. There is no rotation of priority. A granted pair keeps the converter for two conversions in a row: first its even input, then its odd input. Arbitration takes place again only after both have finished.

The converter itself is outside the block, which drives it through a start pulse, a channel number and a done strobe with data. Every finished conversion is placed on a registered result port, tagged with its pair number and with the input it came from within the pair. A per-pair pending flag covers the whole two-conversion service. A per-pair completion pulse fires after the first or after the second conversion, as chosen by an early-event control bit that is captured when the pair is granted. The block never restarts a sequence by itself; each pass needs new triggers.

Top module: `pairconv_seq`

## Requirements
- R1: After reset, cv_start, res_valid, pend and done_evt are all zero, and no conversion starts until a trigger arrives.
- R2: When more than one pair is latched, the pair with the lowest index is granted next; the priority is fixed and never rotates.
- R3: A grant runs exactly two conversions for the same pair, the even input first and the odd input second. cv_chan equals 2*pair + odd, where odd is 0 for the even input and 1 for the odd input. No other pair is granted between the two conversions.
- R4: pend is one-hot with bit p set from the cycle after pair p is granted until the second result of p appears. In the cycle that result is on the port, pend is zero.
- R5: With the early bit captured as 1 at grant, done_evt bit p pulses together with the first result of pair p. With the early bit captured as 0, it pulses together with the second result. A change of early_evt_en during a service has no effect on that service.
- R6: One cycle after cv_done, res_valid is high for one cycle, with res_data equal to cv_data, res_pair equal to the pair and res_odd equal to the input index. done_evt is never set without res_valid.
- R7: Triggers for several pairs in the same cycle are each served once, in ascending pair order.
- R8: Once all latched requests have been served, no further cv_start appears without a new trigger.
- R9: Any number of triggers for a pair that arrive while a pair is being served set that pair's latch only once. The pair is served once after the current service ends.
- R10: cv_start is a single-cycle pulse, and there is no further cv_start until cv_done for that conversion has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_req | input | 6 | Per-pair trigger, sampled every cycle |
| early_evt_en | input | 1 | Selects early (after first conversion) completion event; captured at grant |
| cv_start | output | 1 | One-cycle start pulse to the converter |
| cv_chan | output | 4 | Input to convert: 2*pair + odd |
| cv_done | input | 1 | Converter done strobe |
| cv_data | input | 10 | Converter result, valid with cv_done |
| res_valid | output | 1 | Result strobe |
| res_data | output | 10 | Converted value |
| res_pair | output | 3 | Pair index of the result |
| res_odd | output | 1 | Input within the pair (0 even, 1 odd) |
| pend | output | 6 | Per-pair pending flag |
| done_evt | output | 6 | Per-pair completion event pulse |

## Verification
A corrupted trigger latch shows at the ports within one service. A pair may be converted twice, skipped, or converted out of ascending order. It may also be started again after the bus has gone quiet, which the quiet window following each sequence catches. A wrong input-index or early-flag register shows at the very next result: res_odd is wrong, the data tag is wrong, or done_evt is misplaced. A stale pend register shows in the cycle the second result appears, or at the next cv_start, where the channel no longer matches the pending bit.

// File: rtl/pairconv_pkg.sv
package pairconv_pkg;
    localparam int PC_NPAIRS_DEF = 6;
    localparam int PC_RES_W_DEF  = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pairconv_arb.sv
module pairconv_arb #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  trig,
    input  logic          take,
    output logic          any_req,
    output logic [IW-1:0] sel_idx
);
    logic [N-1:0] lat_q;
    logic [N-1:0] clr_mask;

    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lat_q[i]) sel_idx = IW'(i);
        end
    end

    assign any_req  = |lat_q;
    assign clr_mask = take ? (N'(1) << sel_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= (lat_q & ~clr_mask) | trig;
    end

    // R2: the granted pair has no lower-numbered latched request
    a_r2_lowest_first: assert property (@(posedge clk) disable iff (rst)
        take |-> (any_req && ((lat_q & ((N'(1) << sel_idx) - N'(1))) == '0)));
endmodule

// File: rtl/pairconv_fsm.sv
module pairconv_fsm
    import pairconv_pkg::*;
#(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any_req,
    input  logic [IW-1:0] sel_idx,
    input  logic          early_in,
    input  logic          cv_done,
    output logic          take,
    output logic          cv_start,
    output logic [IW-1:0] cur_pair,
    output logic          cur_odd,
    output logic          early_q,
    output logic          fin_first,
    output logic          fin_second
);
    seq_state_e state_q;

    assign take       = (state_q == ST_IDLE) && any_req;
    assign cv_start   = (state_q == ST_START);
    assign fin_first  = (state_q == ST_WAIT) && cv_done && !cur_odd;
    assign fin_second = (state_q == ST_WAIT) && cv_done &&  cur_odd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_pair <= '0;
            cur_odd  <= 1'b0;
            early_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_req) begin
                        state_q  <= ST_START;
                        cur_pair <= sel_idx;
                        cur_odd  <= 1'b0;
                        early_q  <= early_in;
                    end
                end
                ST_START: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (cv_done) begin
                        if (!cur_odd) begin
                            cur_odd <= 1'b1;
                            state_q <= ST_START;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: start is a single-cycle pulse
    a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
        cv_start |=> !cv_start);
    // R3: the first conversion is followed by the odd input of the same pair
    a_r3_same_pair_odd: assert property (@(posedge clk) disable iff (rst)
        fin_first |=> (cv_start && cur_odd && $stable(cur_pair)));
    // R8: with nothing latched the sequencer stays idle
    a_r8_no_self_loop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !any_req) |=> !cv_start);
endmodule

// File: rtl/pairconv_outs.sv
module pairconv_outs #(
    parameter int N  = 6,
    parameter int IW = $clog2(N),
    parameter int RW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [IW-1:0] sel_idx,
    input  logic          fin_first,
    input  logic          fin_second,
    input  logic [IW-1:0] cur_pair,
    input  logic          cur_odd,
    input  logic          early_q,
    input  logic [RW-1:0] cv_data,
    output logic          res_valid,
    output logic [RW-1:0] res_data,
    output logic [IW-1:0] res_pair,
    output logic          res_odd,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  done_evt
);
    logic fire_evt;
    assign fire_evt = (fin_first && early_q) || (fin_second && !early_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_pair  <= '0;
            res_odd   <= 1'b0;
            pend      <= '0;
            done_evt  <= '0;
        end else begin
            res_valid <= fin_first || fin_second;
            if (fin_first || fin_second) begin
                res_data <= cv_data;
                res_pair <= cur_pair;
                res_odd  <= cur_odd;
            end
            if (take)            pend <= N'(1) << sel_idx;
            else if (fin_second) pend <= '0;
            done_evt <= fire_evt ? (N'(1) << cur_pair) : '0;
        end
    end

    // R4: at most one pair pending
    a_r4_pend_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pend));
    // R4: second conversion of a pair ends its pending flag
    a_r4_pend_clears: assert property (@(posedge clk) disable iff (rst)
        fin_second |=> (pend == '0));
    // R6: a completion event only accompanies a result
    a_r6_evt_with_result: assert property (@(posedge clk) disable iff (rst)
        (done_evt != '0) |-> (res_valid && $onehot(done_evt)));
endmodule

// File: rtl/pairconv_seq.sv
module pairconv_seq
    import pairconv_pkg::*;
#(
    parameter int N_PAIRS = PC_NPAIRS_DEF,
    parameter int RES_W   = PC_RES_W_DEF,
    localparam int IW     = $clog2(N_PAIRS),
    localparam int CW     = IW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PAIRS-1:0] trig_req,
    input  logic               early_evt_en,
    output logic               cv_start,
    output logic [CW-1:0]      cv_chan,
    input  logic               cv_done,
    input  logic [RES_W-1:0]   cv_data,
    output logic               res_valid,
    output logic [RES_W-1:0]   res_data,
    output logic [IW-1:0]      res_pair,
    output logic               res_odd,
    output logic [N_PAIRS-1:0] pend,
    output logic [N_PAIRS-1:0] done_evt
);
    logic          any_req;
    logic [IW-1:0] sel_idx;
    logic          take;
    logic [IW-1:0] cur_pair;
    logic          cur_odd;
    logic          early_q;
    logic          fin_first;
    logic          fin_second;

    pairconv_arb #(.N(N_PAIRS), .IW(IW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig_req),
        .take    (take),
        .any_req (any_req),
        .sel_idx (sel_idx)
    );

    pairconv_fsm #(.N(N_PAIRS), .IW(IW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .any_req    (any_req),
        .sel_idx    (sel_idx),
        .early_in   (early_evt_en),
        .cv_done    (cv_done),
        .take       (take),
        .cv_start   (cv_start),
        .cur_pair   (cur_pair),
        .cur_odd    (cur_odd),
        .early_q    (early_q),
        .fin_first  (fin_first),
        .fin_second (fin_second)
    );

    pairconv_outs #(.N(N_PAIRS), .IW(IW), .RW(RES_W)) u_outs (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .sel_idx    (sel_idx),
        .fin_first  (fin_first),
        .fin_second (fin_second),
        .cur_pair   (cur_pair),
        .cur_odd    (cur_odd),
        .early_q    (early_q),
        .cv_data    (cv_data),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_pair   (res_pair),
        .res_odd    (res_odd),
        .pend       (pend),
        .done_evt   (done_evt)
    );

    assign cv_chan = {cur_pair, cur_odd};

    // R4: a started conversion belongs to the pending pair
    a_r4_start_is_pending: assert property (@(posedge clk) disable iff (rst)
        cv_start |-> (pend == (N_PAIRS'(1) << cur_pair)));
endmodule

// File: tb/pairconv_seq_bench.sv
module pairconv_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] trig_req = '0;
    logic       early_evt_en = 1'b0;
    logic       cv_start;
    logic [3:0] cv_chan;
    logic       cv_done;
    logic [9:0] cv_data;
    logic       res_valid;
    logic [9:0] res_data;
    logic [2:0] res_pair;
    logic       res_odd;
    logic [5:0] pend;
    logic [5:0] done_evt;

    always #5 clk = ~clk;

    pairconv_seq u_pairconv_seq (
        .clk(clk), .rst(rst), .trig_req(trig_req), .early_evt_en(early_evt_en),
        .cv_start(cv_start), .cv_chan(cv_chan), .cv_done(cv_done), .cv_data(cv_data),
        .res_valid(res_valid), .res_data(res_data), .res_pair(res_pair), .res_odd(res_odd),
        .pend(pend), .done_evt(done_evt)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] calc(input int ch, input int n);
        return 10'((ch * 97 + n * 13) & 1023);
    endfunction

    // converter model: fixed latency after start
    int         cnt;
    logic       cv_busy;
    logic [3:0] ch_q;
    int         conv_n;
    always @(posedge clk) begin
        if (rst) begin
            cv_busy <= 1'b0; cv_done <= 1'b0; cv_data <= '0;
            conv_n <= 0; cnt <= 0; ch_q <= '0;
        end else begin
            cv_done <= 1'b0;
            if (cv_start) begin
                cv_busy <= 1'b1; cnt <= 3; ch_q <= cv_chan;
            end else if (cv_busy) begin
                if (cnt == 0) begin
                    cv_done <= 1'b1;
                    cv_data <= calc(int'(ch_q), conv_n);
                    conv_n  <= conv_n + 1;
                    cv_busy <= 1'b0;
                end else cnt <= cnt - 1;
            end
        end
    end

    // expected result stream
    int exp_pair  [0:63];
    int exp_odd   [0:63];
    bit exp_early [0:63];
    int wr = 0;
    int rd = 0;
    int nres = 0;
    int n_starts = 0;

    task automatic push_pair(input int p, input bit e);
        for (int k = 0; k < 2; k++) begin
            exp_pair[wr % 64] = p; exp_odd[wr % 64] = k; exp_early[wr % 64] = e;
            wr++;
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (cv_start) begin
                n_starts++;
                chk("R4 pend at start", pend == 6'(1 << cv_chan[3:1]), int'(pend), 1 << cv_chan[3:1]);
            end
            if (res_valid) begin
                if (rd >= wr) begin
                    chk("R8 unexpected result", 1'b0, int'(res_pair), -1);
                end else begin
                    int p; int o; bit e; int ev;
                    p = exp_pair[rd % 64]; o = exp_odd[rd % 64]; e = exp_early[rd % 64];
                    chk("R2 R7 result pair order", int'(res_pair) == p, int'(res_pair), p);
                    chk("R3 input index", int'(res_odd) == o, int'(res_odd), o);
                    chk("R6 result data", res_data == calc(p * 2 + o, nres), int'(res_data), int'(calc(p * 2 + o, nres)));
                    ev = ((e && o == 0) || (!e && o == 1)) ? (1 << p) : 0;
                    chk("R5 completion event", int'(done_evt) == ev, int'(done_evt), ev);
                    chk("R4 pend during result", int'(pend) == ((o == 0) ? (1 << p) : 0), int'(pend), (o == 0) ? (1 << p) : 0);
                    rd++;
                end
                nres++;
            end else if (done_evt != '0) begin
                chk("R6 event without result", 1'b0, int'(done_evt), 0);
            end
        end
    end

    task automatic drain_and_quiet(input string tag);
        int guard = 0;
        int s0;
        while (rd < wr && guard < 400) begin @(negedge clk); guard++; end
        chk("R7 all requests served", rd == wr, rd, wr);
        s0 = n_starts;
        repeat (30) @(negedge clk);
        chk("R8 no restart without trigger", n_starts == s0, n_starts, s0);
        chk("R4 pend idle", pend == '0, int'(pend), 0);
    endtask

    task automatic run_mask(input int m, input bit e);
        early_evt_en = e;
        for (int i = 0; i < 6; i++) if (m[i]) push_pair(i, e);
        @(negedge clk); trig_req = 6'(m);
        @(negedge clk); trig_req = '0;
        drain_and_quiet("mask");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cv_start", cv_start == 1'b0, int'(cv_start), 0);
        chk("R1 res_valid", res_valid == 1'b0, int'(res_valid), 0);
        chk("R1 pend", pend == '0, int'(pend), 0);
        chk("R1 done_evt", done_evt == '0, int'(done_evt), 0);
        repeat (10) @(negedge clk);
        chk("R1 no start before trigger", n_starts == 0, n_starts, 0);

        // sweep every trigger combination with both event modes (R2 R3 R5 R7)
        for (int e = 0; e < 2; e++)
            for (int m = 1; m < 64; m++)
                run_mask(m, 1'(e));

        // R9 retrigger during service, R5 early bit captured at grant, R10 start held
        begin
            int s0;
            early_evt_en = 1'b1;
            push_pair(3, 1'b1);
            push_pair(0, 1'b0);
            push_pair(1, 1'b0);
            push_pair(3, 1'b0);
            @(negedge clk); trig_req = 6'b001000;
            @(negedge clk); trig_req = '0;
            while (pend != 6'b001000) @(negedge clk);
            early_evt_en = 1'b0;
            s0 = n_starts;
            trig_req = 6'b000001; @(negedge clk);
            trig_req = 6'b001010; @(negedge clk);
            trig_req = '0;        @(negedge clk);
            trig_req = 6'b000001; @(negedge clk);
            trig_req = '0;
            chk("R10 one start per conversion", n_starts - s0 <= 1, n_starts - s0, 1);
            drain_and_quiet("retrig");
            chk("R9 each retriggered pair served once", nres == rd, nres, rd);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule